// File: doc/BRIEF.md
# Two-Pass Lookup Page Sequencer

Every crossing is served by two reads of a paged lookup memory. The first read yields the transverse momentum components. The second yields the total-energy value that feeds the tile sums. This sequencer drives a 3-bit page address into that memory. The upper address bit selects the pass and the two lower bits come from a static page-select setting. The sequencer also produces the strobes that let downstream collection stages latch only the second-pass result.

A single-cycle crossing start, accepted while idle, launches pass one for `PASS1_TICKS` clock cycles, and then pass two. A second-stage capture strobe fires `CAP2_DLY` ticks after the first pass-two cycle. A third-stage strobe follows `CAP3_DLY` ticks after that, and the sequencer then returns to idle. A start that arrives while a crossing is still in progress is dropped and reported on an overrun output.

Top module: `twopass_page_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, page_addr_o is 3'b000 and pass2_o, p1_valid_o, cap2_stb_o, cap3_stb_o and overrun_o are all 0.
- R2: A start_i sampled high at a rising edge while idle begins pass one on the following cycle. For PASS1_TICKS (default 4) cycles, page_addr_o[2] and pass2_o are 0.
- R3: Pass two follows pass one directly and lasts CAP2_DLY+CAP3_DLY+1 (default 10) cycles. During those cycles page_addr_o[2] and pass2_o are both 1. Afterwards both return to 0.
- R4: With LATCH_CFG=1 (default), page_addr_o[1:0] equal the cfg_page_i value sampled at the edge that accepted the start. Later changes to cfg_page_i have no effect on them until the next accepted start.
- R5: p1_valid_o is high for exactly one cycle per crossing, on the last cycle of pass one.
- R6: cap2_stb_o is high for exactly one cycle per crossing, CAP2_DLY (default 5) cycles after the first pass-two cycle, and only while pass2_o is 1.
- R7: cap3_stb_o is high for exactly one cycle per crossing, CAP3_DLY (default 4) cycles after cap2_stb_o. This is the last cycle of pass two.
- R8: A start_i sampled high while a crossing is in progress, including its final cycle, leaves the running crossing unchanged. It sets overrun_o high for the single following cycle.
- R9: A start_i sampled on the first idle cycle after a crossing completes is accepted and begins a new crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all outputs change on its rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Crossing start pulse |
| cfg_page_i | input | 2 | Static lower page-select bits |
| page_addr_o | output | 3 | Lookup page address; bit 2 is the pass select |
| pass2_o | output | 1 | High during the second pass |
| p1_valid_o | output | 1 | First-pass result valid, last pass-one cycle |
| cap2_stb_o | output | 1 | Second-stage capture strobe |
| cap3_stb_o | output | 1 | Third-stage capture strobe |
| overrun_o | output | 1 | A start was dropped on the previous cycle |

## Verification
Two events can fall in the same cycle: the end of pass two, marked by the third-stage strobe, and the rejection of a start that arrives on that final cycle. The bench provokes this by sweeping the offset of a second start over every cycle of a crossing and one cycle beyond. At the boundary offset the bench expects both the strobe and the rejection, a return to idle with no restart, and overrun one cycle later. One offset further, it expects a fresh crossing with newly latched page bits.

// File: rtl/tps_pkg.sv
package tps_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ONE  = 2'd1,
      PH_TWO  = 2'd2
   } phase_e;
endpackage

// File: rtl/tps_phase_fsm.sv
module tps_phase_fsm
   import tps_pkg::*;
#(
   parameter int PASS1_TICKS = 4,
   parameter int PASS2_TICKS = 10,
   parameter int CNT_W       = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output phase_e           phase_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             accept_o,
   output logic             overrun_o
);
   localparam logic [CNT_W-1:0] P1_LAST = CNT_W'(PASS1_TICKS - 1);
   localparam logic [CNT_W-1:0] P2_LAST = CNT_W'(PASS2_TICKS - 1);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;

   assign accept_o = start_i && (phase_q == PH_IDLE);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         overrun_o <= 1'b0;
      end else begin
         overrun_o <= start_i && (phase_q != PH_IDLE);
         unique case (phase_q)
            PH_IDLE: begin
               cnt_q <= '0;
               if (start_i) phase_q <= PH_ONE;
            end
            PH_ONE: begin
               if (cnt_q == P1_LAST) begin
                  phase_q <= PH_TWO;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_TWO: begin
               if (cnt_q == P2_LAST) begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               phase_q <= PH_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign phase_o = phase_q;
   assign cnt_o   = cnt_q;
endmodule

// File: rtl/tps_cfg_hold.sv
module tps_cfg_hold #(
   parameter int CFG_W     = 2,
   parameter bit LATCH_CFG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             accept_i,
   input  logic [CFG_W-1:0] cfg_i,
   output logic [CFG_W-1:0] cfg_o
);
   generate
      if (LATCH_CFG) begin : g_latch
         logic [CFG_W-1:0] cfg_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)       cfg_q <= '0;
            else if (accept_i) cfg_q <= cfg_i;
         end
         assign cfg_o = cfg_q;
      end else begin : g_pass
         assign cfg_o = cfg_i;
      end
   endgenerate
endmodule

// File: rtl/tps_strobe_dec.sv
module tps_strobe_dec
   import tps_pkg::*;
#(
   parameter int PASS1_TICKS = 4,
   parameter int CAP2_DLY    = 5,
   parameter int CAP3_DLY    = 4,
   parameter int CNT_W       = 4
) (
   input  phase_e           phase_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             p1_valid_o,
   output logic             cap2_o,
   output logic             cap3_o
);
   localparam logic [CNT_W-1:0] P1_LAST = CNT_W'(PASS1_TICKS - 1);
   localparam logic [CNT_W-1:0] C2_AT   = CNT_W'(CAP2_DLY);
   localparam logic [CNT_W-1:0] C3_AT   = CNT_W'(CAP2_DLY + CAP3_DLY);

   always_comb begin
      p1_valid_o = (phase_i == PH_ONE) && (cnt_i == P1_LAST);
      cap2_o     = (phase_i == PH_TWO) && (cnt_i == C2_AT);
      cap3_o     = (phase_i == PH_TWO) && (cnt_i == C3_AT);
   end
endmodule

// File: rtl/twopass_page_seq.sv
module twopass_page_seq
   import tps_pkg::*;
#(
   parameter int PASS1_TICKS = 4,
   parameter int CAP2_DLY    = 5,
   parameter int CAP3_DLY    = 4,
   parameter bit LATCH_CFG   = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       start_i,
   input  logic [1:0] cfg_page_i,
   output logic [2:0] page_addr_o,
   output logic       pass2_o,
   output logic       p1_valid_o,
   output logic       cap2_stb_o,
   output logic       cap3_stb_o,
   output logic       overrun_o
);
   localparam int CFG_W       = 2;
   localparam int PASS2_TICKS = CAP2_DLY + CAP3_DLY + 1;
   localparam int MAX_TICKS   = (PASS1_TICKS > PASS2_TICKS) ? PASS1_TICKS : PASS2_TICKS;
   localparam int CNT_W       = $clog2(MAX_TICKS + 1);

   initial begin
      assert (PASS1_TICKS >= 1) else $error("PASS1_TICKS must be at least 1");
      assert (CAP2_DLY >= 1)    else $error("CAP2_DLY must be at least 1");
      assert (CAP3_DLY >= 1)    else $error("CAP3_DLY must be at least 1");
   end

   phase_e           phase;
   logic [CNT_W-1:0] cnt;
   logic             accept;
   logic [CFG_W-1:0] cfg_lo;

   tps_phase_fsm #(
      .PASS1_TICKS(PASS1_TICKS),
      .PASS2_TICKS(PASS2_TICKS),
      .CNT_W      (CNT_W)
   ) u_fsm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .phase_o  (phase),
      .cnt_o    (cnt),
      .accept_o (accept),
      .overrun_o(overrun_o)
   );

   tps_cfg_hold #(
      .CFG_W    (CFG_W),
      .LATCH_CFG(LATCH_CFG)
   ) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .accept_i(accept),
      .cfg_i   (cfg_page_i),
      .cfg_o   (cfg_lo)
   );

   tps_strobe_dec #(
      .PASS1_TICKS(PASS1_TICKS),
      .CAP2_DLY   (CAP2_DLY),
      .CAP3_DLY   (CAP3_DLY),
      .CNT_W      (CNT_W)
   ) u_dec (
      .phase_i   (phase),
      .cnt_i     (cnt),
      .p1_valid_o(p1_valid_o),
      .cap2_o    (cap2_stb_o),
      .cap3_o    (cap3_stb_o)
   );

   assign pass2_o     = (phase == PH_TWO);
   assign page_addr_o = {pass2_o, cfg_lo};
endmodule

// File: rtl/tps_checker.sv
module tps_checker (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       start_i,
   input logic [2:0] page_addr_o,
   input logic       pass2_o,
   input logic       p1_valid_o,
   input logic       cap2_stb_o,
   input logic       cap3_stb_o,
   input logic       overrun_o
);
   a_r3_pass_msb_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pass2_o == page_addr_o[2]);

   a_r3_entry_after_p1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pass2_o) |-> $past(p1_valid_o));

   a_r5_p1_then_pass2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      p1_valid_o |=> pass2_o);

   a_r6_cap2_in_pass2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap2_stb_o |-> pass2_o);

   a_r7_cap3_ends_pass2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap3_stb_o |=> !pass2_o);

   a_r6_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({p1_valid_o, cap2_stb_o, cap3_stb_o}));

   a_r4_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pass2_o && $past(pass2_o)) |-> $stable(page_addr_o[1:0]));

   a_r8_overrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overrun_o |-> $past(start_i));
endmodule

bind twopass_page_seq tps_checker u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .start_i    (start_i),
   .page_addr_o(page_addr_o),
   .pass2_o    (pass2_o),
   .p1_valid_o (p1_valid_o),
   .cap2_stb_o (cap2_stb_o),
   .cap3_stb_o (cap3_stb_o),
   .overrun_o  (overrun_o)
);

// File: tb/sim_twopass_page_seq.sv
`timescale 1ns/1ps
module sim_twopass_page_seq;
   localparam int P1  = 4;
   localparam int C2  = 5;
   localparam int C3  = 4;
   localparam int TOT = P1 + C2 + C3 + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] cfg = 2'd0;
   logic [2:0] page;
   logic       pass2, p1v, cap2, cap3, ovr;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   // bench model state
   int         n_exp = -1;
   logic [1:0] cfg_exp = 2'd0;
   logic       ovr_exp = 1'b0;

   always #2 clk = ~clk;

   twopass_page_seq u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_page_i(cfg),
      .page_addr_o(page), .pass2_o(pass2), .p1_valid_o(p1v),
      .cap2_stb_o(cap2), .cap3_stb_o(cap3), .overrun_o(ovr)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s cycle %0d n=%0d actual=%0d expected=%0d", tag, cycles, n_exp, act, exp);
      end
   endtask

   task automatic compare_all();
      logic busy;
      busy = (n_exp >= 0);
      chk("R3 pass2", pass2, (busy && n_exp >= P1) ? 1 : 0);
      chk("R2 page msb", page[2], (busy && n_exp >= P1) ? 1 : 0);
      chk("R4 page low", page[1:0], cfg_exp);
      chk("R5 p1_valid", p1v, (n_exp == P1 - 1) ? 1 : 0);
      chk("R6 cap2", cap2, (n_exp == P1 + C2) ? 1 : 0);
      chk("R7 cap3", cap3, (n_exp == TOT - 1) ? 1 : 0);
      chk("R8 overrun", ovr, ovr_exp);
   endtask

   // called at a falling edge: drive, take the rising edge, update model, compare
   task automatic step(input logic s, input logic [1:0] c);
      logic was_busy;
      start = s;
      cfg   = c;
      @(posedge clk);
      was_busy = (n_exp >= 0);
      ovr_exp  = s && was_busy;
      if (was_busy) begin
         n_exp = n_exp + 1;
         if (n_exp == TOT) n_exp = -1;
      end else if (s) begin
         n_exp   = 0;
         cfg_exp = c;
      end
      @(negedge clk);
      compare_all();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      compare_all();
      rst_n = 1'b1;
      step(1'b0, 2'd0);

      // sweep: config value x offset of a second start (-1 none, 0..TOT beyond)
      for (int c = 0; c < 4; c++) begin
         for (int j = -1; j <= TOT; j++) begin
            for (int k = 0; k < 2 * TOT + 4; k++) begin
               logic s;
               logic [1:0] cv;
               s  = (k == 0) || (j >= 0 && k == j + 1);
               cv = (k >= 2) ? ~c[1:0] : c[1:0];
               // j==TOT-1: second start lands on the cap3 cycle (R7/R8 collision)
               // j==TOT: first idle cycle, new crossing expected (R9)
               step(s, cv);
            end
         end
      end

      // start held high for a long stretch: R8 repeated overruns, R9 back-to-back
      for (int k = 0; k < 3 * TOT; k++) step(1'b1, k[1:0]);
      for (int k = 0; k < TOT + 2; k++) step(1'b0, 2'd0);

      // reset mid-crossing returns to R1 state
      step(1'b1, 2'd3);
      step(1'b0, 2'd3);
      rst_n = 1'b0;
      n_exp = -1; cfg_exp = 2'd0; ovr_exp = 1'b0;
      @(posedge clk);
      @(negedge clk);
      compare_all();
      rst_n = 1'b1;
      step(1'b0, 2'd1);

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule